// File: doc/BRIEF.md
# PCIe Configuration Window Decoder

This block sits in a host bridge. It holds the 64-bit register that places the memory-mapped PCIe configuration window. Firmware writes the register one byte lane at a time through a configuration-write port, which carries a byte address, per-lane byte enables and a data word. From the register contents the block works out three things: whether the window is switched on, how large it is, and the aligned base address.

Each memory address presented to the block is tested against the window. When the window is on, the length code is legal and the address falls inside the window, the block raises a hit. It then splits the offset into the window into bus, device, function and register fields, so that a downstream forwarder can turn the access into a configuration transaction. A reserved length code raises an error flag, and while that code is present nothing decodes.

The length code also changes how finely the base may be placed. The widest window aligns its base to its own size. The two smaller codes let extra low base bits through the mask, in a fixed, non-monotonic pattern.

Top module: `cfgwin_decoder`

## Requirements
- R1: On a synchronous active-low reset the register takes RST_VALUE (default 0x00000000_B0000000). The window is then off, the length code is 256 MB, the base is 0xB0000000 and cfg_err is low.
- R2: Register bit 0 enables the window. While it is 0, hit stays low for every address.
- R3: Register bits 2:1 select the length: 00 gives 256 MB, 01 gives 128 MB and 10 gives 64 MB.
- R4: Length code 11 is reserved. It drives cfg_err high and keeps hit low for every address.
- R5: The base is the register ANDed with a mask. For 256 MB the mask covers bits 35:28. For 128 MB it also covers bits 27 and 26. For 64 MB it also covers bit 26 only. Register bits above 35 and below the mask are ignored.
- R6: Byte lane i of a write targets byte address cfg_wr_addr+i and carries data bits 8i+7:8i. The lane updates register byte k only when its enable is set and that address equals REG_OFFSET+k (default REG_OFFSET 0x60). All other register bytes are unchanged, so a write that misses 0x60..0x67 has no effect.
- R7: A write takes effect at the clock edge that samples it. win_en, cfg_err and the decode follow from that edge, and before that edge they show the old value.
- R8: hit is high exactly when the window is on, the length code is legal, and base <= mem_addr < base + length. It follows mem_addr in the same cycle.
- R9: On a hit the offset mem_addr - base splits into bus = offset[27:20], device = offset[19:15], function = offset[14:12] and register = offset[11:0]. On a miss all four fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | CFG_AW | Byte address of lane 0 |
| cfg_wr_be | input | LANES | Per-lane byte enables |
| cfg_wr_data | input | 8*LANES | Write data, lane i in bits 8i+7:8i |
| mem_addr | input | ADDR_W | Memory address to test |
| win_en | output | 1 | Window enable from register bit 0 |
| cfg_err | output | 1 | Reserved length code present |
| hit | output | 1 | mem_addr falls inside the live window |
| cfg_bus | output | 8 | Bus number on a hit |
| cfg_dev | output | 5 | Device number on a hit |
| cfg_fn | output | 3 | Function number on a hit |
| cfg_reg | output | 12 | Register offset on a hit |

## Verification
The register is the only state, so every result of a write is due one clock edge after that write is sampled. The address decode is purely combinational and is due in the same cycle as the address. The bench drives inputs on the falling edge. Once a write is released it samples on the following falling edge, and after an address change it samples a short delay later. One directed test samples just before the write edge and again just after it, to confirm that the old value holds until the edge and that the new value appears at it.

// File: rtl/cfgwin_pkg.sv
// Shared types for the configuration window decoder.
// Assumes the standard PCIe split of a 28-bit window offset into
// bus, device, function and register fields.
package cfgwin_pkg;

    // Window length code carried in register bits 2:1
    typedef enum logic [1:0] {
        LEN_256M = 2'b00,
        LEN_128M = 2'b01,
        LEN_64M  = 2'b10,
        LEN_RSVD = 2'b11
    } win_len_e;

    localparam int BUS_W = 8;
    localparam int DEV_W = 5;
    localparam int FN_W  = 3;
    localparam int REG_W = 12;
    localparam int OFF_W = BUS_W + DEV_W + FN_W + REG_W;

    // Decoded routing fields of one configuration access
    typedef struct packed {
        logic [BUS_W-1:0] bus;
        logic [DEV_W-1:0] dev;
        logic [FN_W-1:0]  fn;
        logic [REG_W-1:0] rg;
    } bdf_t;

endpackage

// File: rtl/cfgwin_reg.sv
// Byte-writable window register.
// Each write lane addresses one byte; a lane updates register byte k
// only when its enable is set and its byte address equals REG_OFFSET+k.
// Assumes the register does not straddle the top of the config space.
module cfgwin_reg #(
    parameter int CFG_AW     = 8,
    parameter int LANES      = 4,
    parameter int REG_BYTES  = 8,
    parameter int REG_OFFSET = 'h60,
    parameter logic [8*REG_BYTES-1:0] RST_VALUE = 64'h0000_0000_B000_0000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [CFG_AW-1:0]      wr_addr,
    input  logic [LANES-1:0]       wr_be,
    input  logic [8*LANES-1:0]     wr_data,
    output logic [8*REG_BYTES-1:0] reg_q
);
    localparam int AXW = CFG_AW + 1;

    logic [7:0] byte_q [REG_BYTES];

    for (genvar b = 0; b < REG_BYTES; b++) begin : g_byte
        logic       sel;
        logic [7:0] nxt;

        // Find the lane, if any, that lands on this register byte
        always_comb begin
            sel = 1'b0;
            nxt = byte_q[b];
            for (int l = 0; l < LANES; l++) begin
                if (wr_en && wr_be[l] &&
                    (AXW'(wr_addr) + AXW'(l) == AXW'(REG_OFFSET + b))) begin
                    sel = 1'b1;
                    nxt = wr_data[8*l +: 8];
                end
            end
        end

        // Hold the byte, load reset value or the selected lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                byte_q[b] <= RST_VALUE[8*b +: 8];
            end else if (sel) begin
                byte_q[b] <= nxt;
            end
        end

        assign reg_q[8*b +: 8] = byte_q[b];
    end

endmodule

// File: rtl/cfgwin_len_decode.sv
// Derives enable, error, length and masked base from the register.
// Bit 0 enables, bits 2:1 pick the length. The basic mask spans
// MASK_HI down to LOG2_MAX. The 128 MB code adds the two bits below it,
// and the 64 MB code adds only the lower of those two.
// Assumes ADDR_W > MASK_HI and LOG2_MAX >= 2.
module cfgwin_len_decode
    import cfgwin_pkg::*;
#(
    parameter int ADDR_W   = 40,
    parameter int MASK_HI  = 35,
    parameter int LOG2_MAX = 28,
    parameter int REG_W64  = 64
) (
    input  logic [REG_W64-1:0] reg_val,
    output logic               en,
    output logic               err,
    output win_len_e           len_code,
    output logic [ADDR_W-1:0]  base,
    output logic [ADDR_W-1:0]  len_bytes
);
    localparam int LEN_LSB = 1;

    logic [ADDR_W-1:0] mask;

    // Decode length code into window size and base mask
    always_comb begin
        len_code = win_len_e'(reg_val[LEN_LSB +: 2]);
        en       = reg_val[0];
        err      = (len_code == LEN_RSVD);
        mask     = '0;
        for (int i = 0; i < ADDR_W; i++) begin
            if (i >= LOG2_MAX && i <= MASK_HI) mask[i] = 1'b1;
        end
        case (len_code)
            LEN_256M: len_bytes = ADDR_W'(1) << LOG2_MAX;
            LEN_128M: begin
                len_bytes          = ADDR_W'(1) << (LOG2_MAX - 1);
                mask[LOG2_MAX - 1] = 1'b1;
                mask[LOG2_MAX - 2] = 1'b1;
            end
            LEN_64M: begin
                len_bytes          = ADDR_W'(1) << (LOG2_MAX - 2);
                mask[LOG2_MAX - 2] = 1'b1;
            end
            default: len_bytes = '0;
        endcase
        base = reg_val[ADDR_W-1:0] & mask;
    end

endmodule

// File: rtl/cfgwin_hit.sv
// Range test and offset split for one memory address.
// Assumes the window never exceeds 2**OFF_W bytes, so the field
// split of the offset covers the whole window.
module cfgwin_hit
    import cfgwin_pkg::*;
#(
    parameter int ADDR_W = 40
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              en,
    input  logic              err,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] len_bytes,
    output logic              hit,
    output bdf_t              fields
);
    logic [ADDR_W-1:0] off;
    logic              in_win;

    // Compare against the window and split the offset on a hit
    always_comb begin
        off    = addr - base;
        in_win = (addr >= base) && (off < len_bytes);
        hit    = en && !err && in_win;
        fields = hit ? bdf_t'(off[OFF_W-1:0]) : '0;
    end

endmodule

// File: rtl/cfgwin_decoder.sv
// Top of the configuration window decoder: register, length decode
// and hit logic. The register is the only state, so decode results
// follow a write by one clock edge, and the hit follows mem_addr
// combinationally.
module cfgwin_decoder
    import cfgwin_pkg::*;
#(
    parameter int CFG_AW     = 8,
    parameter int LANES      = 4,
    parameter int ADDR_W     = 40,
    parameter int MASK_HI    = 35,
    parameter int LOG2_MAX   = 28,
    parameter int REG_OFFSET = 'h60,
    parameter logic [63:0] RST_VALUE = 64'h0000_0000_B000_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr_en,
    input  logic [CFG_AW-1:0]  cfg_wr_addr,
    input  logic [LANES-1:0]   cfg_wr_be,
    input  logic [8*LANES-1:0] cfg_wr_data,
    input  logic [ADDR_W-1:0]  mem_addr,
    output logic               win_en,
    output logic               cfg_err,
    output logic               hit,
    output logic [7:0]         cfg_bus,
    output logic [4:0]         cfg_dev,
    output logic [2:0]         cfg_fn,
    output logic [11:0]        cfg_reg
);
    localparam int REG_BYTES = 8;

    logic [8*REG_BYTES-1:0] reg_q;
    win_len_e               len_code;
    logic [ADDR_W-1:0]      win_base;
    logic [ADDR_W-1:0]      win_len;
    bdf_t                   fields;

    cfgwin_reg #(
        .CFG_AW(CFG_AW), .LANES(LANES), .REG_BYTES(REG_BYTES),
        .REG_OFFSET(REG_OFFSET), .RST_VALUE(RST_VALUE)
    ) u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr),
        .wr_be(cfg_wr_be), .wr_data(cfg_wr_data), .reg_q(reg_q)
    );

    cfgwin_len_decode #(
        .ADDR_W(ADDR_W), .MASK_HI(MASK_HI), .LOG2_MAX(LOG2_MAX),
        .REG_W64(8*REG_BYTES)
    ) u_dec (
        .reg_val(reg_q), .en(win_en), .err(cfg_err), .len_code(len_code),
        .base(win_base), .len_bytes(win_len)
    );

    cfgwin_hit #(.ADDR_W(ADDR_W)) u_hit (
        .addr(mem_addr), .en(win_en), .err(cfg_err), .base(win_base),
        .len_bytes(win_len), .hit(hit), .fields(fields)
    );

    assign cfg_bus = fields.bus;
    assign cfg_dev = fields.dev;
    assign cfg_fn  = fields.fn;
    assign cfg_reg = fields.rg;

endmodule

// File: rtl/cfgwin_decoder_chk.sv
// Property checker for the configuration window decoder, bound
// into every instance of the top module.
module cfgwin_decoder_chk
    import cfgwin_pkg::*;
#(
    parameter int ADDR_W   = 40,
    parameter int LOG2_MAX = 28,
    parameter logic [63:0] RST_VALUE = 64'h0000_0000_B000_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_en,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              win_en,
    input logic              cfg_err,
    input logic              hit,
    input logic [7:0]        cfg_bus,
    input logic [4:0]        cfg_dev,
    input logic [2:0]        cfg_fn,
    input logic [11:0]       cfg_reg,
    input logic [63:0]       reg_q,
    input win_len_e          len_code,
    input logic [ADDR_W-1:0] win_base
);
    AST_RESET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> reg_q == RST_VALUE); // R1
    AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !win_en |-> !hit); // R2
    AST_RSVD_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !hit); // R4
    AST_WIDE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (len_code == LEN_256M) |-> win_base[LOG2_MAX-1:0] == '0); // R5
    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_en |=> $stable(reg_q)); // R6
    AST_HIT_ABOVE_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> mem_addr >= win_base); // R8
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (cfg_bus == '0 && cfg_dev == '0 && cfg_fn == '0 && cfg_reg == '0)); // R9

endmodule

bind cfgwin_decoder cfgwin_decoder_chk #(
    .ADDR_W(ADDR_W), .LOG2_MAX(LOG2_MAX), .RST_VALUE(RST_VALUE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .mem_addr(mem_addr),
    .win_en(win_en), .cfg_err(cfg_err), .hit(hit), .cfg_bus(cfg_bus),
    .cfg_dev(cfg_dev), .cfg_fn(cfg_fn), .cfg_reg(cfg_reg), .reg_q(reg_q),
    .len_code(len_code), .win_base(win_base)
);

// File: tb/cfgwin_decoder_bench.sv
module cfgwin_decoder_bench;
    localparam int ADDR_W = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_wr_addr = '0;
    logic [3:0]  cfg_wr_be = '0;
    logic [31:0] cfg_wr_data = '0;
    logic [ADDR_W-1:0] mem_addr = '0;
    logic        win_en, cfg_err, hit;
    logic [7:0]  cfg_bus;
    logic [4:0]  cfg_dev;
    logic [2:0]  cfg_fn;
    logic [11:0] cfg_reg;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    cfgwin_decoder u_cfgwin_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
        .cfg_wr_be(cfg_wr_be), .cfg_wr_data(cfg_wr_data), .mem_addr(mem_addr),
        .win_en(win_en), .cfg_err(cfg_err), .hit(hit), .cfg_bus(cfg_bus),
        .cfg_dev(cfg_dev), .cfg_fn(cfg_fn), .cfg_reg(cfg_reg)
    );

    typedef struct packed {
        logic [31:0]       lo;
        logic [31:0]       hi;
        logic [ADDR_W-1:0] addr;
        logic              en;
        logic              err;
        logic              hit;
        logic [7:0]        bus;
        logic [4:0]        dev;
        logic [2:0]        fn;
        logic [11:0]       rg;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t TBL [NV] = '{
        '{32'hB000_0001, 32'h0,  40'h00_B000_0000, 1'b1, 1'b0, 1'b1, 8'h00, 5'h00, 3'h0, 12'h000},
        '{32'hB000_0001, 32'h0,  40'h00_BFFF_FFFF, 1'b1, 1'b0, 1'b1, 8'hFF, 5'h1F, 3'h7, 12'hFFF},
        '{32'hB000_0001, 32'h0,  40'h00_C000_0000, 1'b1, 1'b0, 1'b0, 8'h00, 5'h00, 3'h0, 12'h000},
        '{32'hB000_0001, 32'h0,  40'h00_AFFF_FFFF, 1'b1, 1'b0, 1'b0, 8'h00, 5'h00, 3'h0, 12'h000},
        '{32'hB000_0000, 32'h0,  40'h00_B010_8000, 1'b0, 1'b0, 1'b0, 8'h00, 5'h00, 3'h0, 12'h000},
        '{32'hE000_0003, 32'h0,  40'h00_E7FF_F004, 1'b1, 1'b0, 1'b1, 8'h7F, 5'h1F, 3'h7, 12'h004},
        '{32'hE000_0003, 32'h0,  40'h00_E800_0000, 1'b1, 1'b0, 1'b0, 8'h00, 5'h00, 3'h0, 12'h000},
        '{32'hE400_0003, 32'h0,  40'h00_EBFF_FFFF, 1'b1, 1'b0, 1'b1, 8'h7F, 5'h1F, 3'h7, 12'hFFF},
        '{32'hE800_0005, 32'h0,  40'h00_E800_0000, 1'b1, 1'b0, 1'b0, 8'h00, 5'h00, 3'h0, 12'h000},
        '{32'hE800_0005, 32'h0,  40'h00_E3FF_FFFF, 1'b1, 1'b0, 1'b1, 8'h3F, 5'h1F, 3'h7, 12'hFFF},
        '{32'hE400_0005, 32'h0,  40'h00_E412_3456, 1'b1, 1'b0, 1'b1, 8'h01, 5'h04, 3'h3, 12'h456},
        '{32'hB000_0007, 32'h0,  40'h00_B000_0000, 1'b1, 1'b1, 1'b0, 8'h00, 5'h00, 3'h0, 12'h000},
        '{32'hB000_0001, 32'h1,  40'h01_B000_0000, 1'b1, 1'b0, 1'b1, 8'h00, 5'h00, 3'h0, 12'h000},
        '{32'hB000_0001, 32'h1,  40'h00_B000_0000, 1'b1, 1'b0, 1'b0, 8'h00, 5'h00, 3'h0, 12'h000},
        '{32'hB000_0001, 32'h10, 40'h00_B000_0000, 1'b1, 1'b0, 1'b1, 8'h00, 5'h00, 3'h0, 12'h000},
        '{32'hBC00_0001, 32'h0,  40'h00_B000_0000, 1'b1, 1'b0, 1'b1, 8'h00, 5'h00, 3'h0, 12'h000}
    };

    task automatic cfg_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_be = be; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_wr_be = '0;
    endtask

    task automatic check(input string req, input logic [ADDR_W-1:0] a,
                         input logic e_en, input logic e_err, input logic e_hit,
                         input logic [7:0] e_bus, input logic [4:0] e_dev,
                         input logic [2:0] e_fn, input logic [11:0] e_rg);
        mem_addr = a;
        #1;
        total++;
        if ({win_en, cfg_err, hit, cfg_bus, cfg_dev, cfg_fn, cfg_reg} !==
            {e_en, e_err, e_hit, e_bus, e_dev, e_fn, e_rg}) begin
            bad++;
            $display("FAIL %s addr=%h actual en=%b err=%b hit=%b bus=%h dev=%h fn=%h reg=%h expected en=%b err=%b hit=%b bus=%h dev=%h fn=%h reg=%h",
                     req, a, win_en, cfg_err, hit, cfg_bus, cfg_dev, cfg_fn, cfg_reg,
                     e_en, e_err, e_hit, e_bus, e_dev, e_fn, e_rg);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state, window off, no error, default base does not hit
        check("R1 reset", 40'h00_B000_0000, 1'b0, 1'b0, 1'b0, 0, 0, 0, 0);

        // R6 R1: lane 0 only sets enable; the other bytes keep the default base
        cfg_write(8'h60, 4'b0001, 32'hFFFF_FF01);
        check("R6 R1 byte0 write", 40'h00_BFFF_FFFF, 1'b1, 1'b0, 1'b1, 8'hFF, 5'h1F, 3'h7, 12'hFFF);

        // R7: old value holds before the write edge, new value after it
        mem_addr = 40'h00_B000_0000;
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_addr = 8'h60; cfg_wr_be = 4'b0001; cfg_wr_data = 32'h0;
        check("R7 before edge", 40'h00_B000_0000, 1'b1, 1'b0, 1'b1, 0, 0, 0, 0);
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_wr_be = '0;
        check("R7 after edge", 40'h00_B000_0000, 1'b0, 1'b0, 1'b0, 0, 0, 0, 0);

        // R6: writes that miss the register leave it unchanged
        cfg_write(8'h60, 4'b0001, 32'h0000_0001);
        cfg_write(8'h68, 4'b1111, 32'h0000_0000);
        cfg_write(8'h5C, 4'b1111, 32'h0000_0000);
        cfg_write(8'h60, 4'b0000, 32'h0000_0000);
        check("R6 no overlap", 40'h00_B000_0010, 1'b1, 1'b0, 1'b1, 8'h00, 5'h00, 3'h0, 12'h010);

        // R6: unaligned write, lane 1 lands on register byte 0
        cfg_write(8'h5F, 4'b0010, 32'h0000_00FF);
        check("R6 unaligned lane", 40'h00_B000_0000, 1'b0, 1'b0, 1'b0, 0, 0, 0, 0);

        // R2 R3 R4 R5 R8 R9: table of register values and addresses
        for (int i = 0; i < NV; i++) begin
            cfg_write(8'h60, 4'b1111, TBL[i].lo);
            cfg_write(8'h64, 4'b1111, TBL[i].hi);
            check($sformatf("R2 R3 R4 R5 R8 R9 vec%0d", i), TBL[i].addr, TBL[i].en,
                  TBL[i].err, TBL[i].hit, TBL[i].bus, TBL[i].dev, TBL[i].fn, TBL[i].rg);
        end

        // R4: reserved code with the 64 MB window start also decodes nothing
        cfg_write(8'h60, 4'b1111, 32'hE000_0007);
        check("R4 reserved", 40'h00_E000_0100, 1'b1, 1'b1, 1'b0, 0, 0, 0, 0);

        // R1: reset in mid-run restores the default
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reapplied reset", 40'h00_E000_0100, 1'b0, 1'b0, 1'b0, 0, 0, 0, 0);
        cfg_write(8'h60, 4'b0001, 32'h0000_0001);
        check("R1 default base", 40'h00_B000_0000, 1'b1, 1'b0, 1'b1, 0, 0, 0, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule